// File: doc/BRIEF.md
# Lane Power-Down Control Port over SMBus

This block is the target side of a two-wire SMBus/I2C management port for an eight-lane signal repeater. It oversamples SCL and SDA with the system clock and detects START and STOP conditions. It answers to one 7-bit device address, which is set by a parameter. The host can do two things through it: write one byte to one register, or read one byte from one register. A read is made of a write that sets the register pointer, followed by a repeated START with the read bit set.

The register file has two registers. Register 0x00 can only be read. It shows the four address-strap inputs and a flag that the configuration load is complete. Register 0x01 can be read and written, and each of its bits powers down one lane. After reset, an external power-down pin drives every lane. The first write to register 0x01 hands lane control to that register until the next reset. SDA is driven as an open-drain pull-down enable.

Top module: `smb_lane_ctl`

## Requirements
- R1: A byte received after START whose upper seven bits equal the device address is acknowledged: SDA is pulled low while the ninth clock is high. On any other address the block never pulls SDA low, and it ignores every further bit and byte until the next START or STOP.
- R2: A write is address with bit 0 = 0, then a pointer byte, then one data byte. The block acknowledges all three bytes. If the pointer is 0x01, lane_pd equals the data byte after the transfer.
- R3: A read is a pointer write, then a repeated START, then address with bit 0 = 1. The block acknowledges, then sends the addressed register MSB first. After the host's ninth-bit NACK it releases SDA (sda_oe = 0).
- R4: Register 0x00 reads as {0, strap_ad[3:0], load_done, 0, 0}: strap_ad[3] sits in bit 6 and load_done in bit 2. Bits 7, 1 and 0 read 0.
- R5: Register 0x01 resets to 0x00 and reads back the last value written to it. lane_pd[i] follows register bit i: bits 7..4 control channel-A lanes 3..0 and bits 3..0 control channel-B lanes 3..0. A bit value of 1 powers the lane down, so 0x00 enables all lanes and 0xFF disables all lanes.
- R6: Until register 0x01 has been written since reset, every lane_pd bit equals pwdn_pin. After that write, lane_pd changes only on later writes to 0x01, and pwdn_pin has no effect on it.
- R7: Writes to register 0x00 or to any pointer other than 0x01 are acknowledged but change nothing. Reads from pointers other than 0x00 and 0x01 return 0x00.
- R8: A STOP anywhere ends the transfer and releases SDA. A START anywhere restarts address reception. A data byte cut short by either condition is not written.
- R9: sda_oe is 0 after reset and changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_ad | input | 4 | Address-strap levels shown in register 0x00 |
| load_done | input | 1 | Configuration load complete, shown in register 0x00 |
| pwdn_pin | input | 1 | External power-down for all lanes before any register write |
| lane_pd | output | 8 | Per-lane power-down, 1 = lane off |

## Verification
The assertions check several things on every cycle. SDA is driven only during an acknowledge slot or a read-data byte, and only while SCL is low. STOP always releases the line, and START clears the bit counter. Once the register owns the lanes, lane_pd moves only on a register write, and it takes the written byte when that write lands. The bench scenarios show the rest: address matching and the mismatch silence, the exact bits sent back on a read, the strap and load-done layout, reserved and unmapped handling, pin ownership before the first write, and the effect of aborting a byte part-way.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } smb_st_e;

  // observation register image: strap in 6:3, load flag in 2
  function automatic logic [REG_W-1:0] obs_pack(input logic [3:0] strap,
                                                input logic done);
    return {1'b0, strap, done, 2'b00};
  endfunction

  function automatic logic addr_hit(input logic [REG_W-1:0] b,
                                    input logic [6:0] dev);
    return b[REG_W-1:1] == dev;
  endfunction

  // before the first register write the pin owns every lane
  function automatic logic [REG_W-1:0] lane_sel(input logic owned,
                                                input logic [REG_W-1:0] regv,
                                                input logic pin);
    return owned ? regv : {REG_W{pin}};
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine import smb_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h58
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [REG_W-1:0] rd_data,
  output logic             sda_oe,
  output logic             wr_stb,
  output logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] reg_ptr,
  output logic             in_ack,
  output logic             in_rd,
  output logic [2:0]       bit_cnt
);
  smb_st_e          st, pend;
  logic [REG_W-1:0] sh;
  logic             full, ackph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; pend <= ST_IDLE; sh <= '0; bit_cnt <= '0;
      full <= 1'b0; ackph <= 1'b0; sda_oe <= 1'b0;
      reg_ptr <= '0; wr_stb <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det || stop_det) begin
        st <= start_det ? ST_ADDR : ST_IDLE;
        bit_cnt <= '0; full <= 1'b0; ackph <= 1'b0; sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (ackph) begin
              if (scl_fall) begin
                ackph <= 1'b0; bit_cnt <= '0; st <= pend;
                if (pend == ST_RDATA) begin
                  sh <= rd_data; sda_oe <= ~rd_data[REG_W-1];
                end else sda_oe <= 1'b0;
              end
            end else if (full) begin
              if (scl_fall) begin
                full <= 1'b0;
                if (st == ST_ADDR) begin
                  if (addr_hit(sh, DEV_ADDR)) begin
                    ackph <= 1'b1; sda_oe <= 1'b1;
                    pend <= sh[0] ? ST_RDATA : ST_PTR;
                  end else st <= ST_SKIP;
                end else if (st == ST_PTR) begin
                  reg_ptr <= sh; ackph <= 1'b1; sda_oe <= 1'b1; pend <= ST_WDATA;
                end else begin
                  wr_stb <= 1'b1; ackph <= 1'b1; sda_oe <= 1'b1; pend <= ST_SKIP;
                end
              end
            end else if (scl_rise) begin
              sh <= {sh[REG_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) full <= 1'b1;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) full <= 1'b1;
            end else if (scl_fall) begin
              if (full) begin
                full <= 1'b0; sda_oe <= 1'b0; st <= ST_RACK;
              end else begin
                sh <= {sh[REG_W-2:0], 1'b0};
                sda_oe <= ~sh[REG_W-2];
              end
            end
          end
          ST_RACK: if (scl_rise) st <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end

  assign wr_data = sh;
  assign in_ack  = ackph;
  assign in_rd   = (st == ST_RDATA);
endmodule

// File: rtl/smb_regs.sv
module smb_regs import smb_pkg::*; #(
  parameter logic [REG_W-1:0] OBS_ADDR = 8'h00,
  parameter logic [REG_W-1:0] PD_ADDR  = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] reg_ptr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [3:0]       strap_ad,
  input  logic             load_done,
  input  logic             pwdn_pin,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] lane_pd,
  output logic [REG_W-1:0] pd_q,
  output logic             wr_seen,
  output logic             pd_we
);
  assign pd_we = wr_stb && (reg_ptr == PD_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q    <= '0;
      wr_seen <= 1'b0;
    end else if (pd_we) begin
      pd_q    <= wr_data;
      wr_seen <= 1'b1;
    end
  end

  always_comb begin
    if (reg_ptr == OBS_ADDR)     rd_data = obs_pack(strap_ad, load_done);
    else if (reg_ptr == PD_ADDR) rd_data = pd_q;
    else                         rd_data = '0;
  end

  assign lane_pd = lane_sel(wr_seen, pd_q, pwdn_pin);
endmodule

// File: rtl/smb_lane_ctl.sv
module smb_lane_ctl import smb_pkg::*; #(
  parameter logic [6:0] DEV_ADDR    = 7'h58,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [3:0]       strap_ad,
  input  logic             load_done,
  input  logic             pwdn_pin,
  output logic [REG_W-1:0] lane_pd
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb, in_ack, in_rd, wr_seen, pd_we;
  logic [2:0] bit_cnt;
  logic [REG_W-1:0] wr_data, reg_ptr, rd_data, pd_q;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_data(wr_data),
    .reg_ptr(reg_ptr), .in_ack(in_ack), .in_rd(in_rd), .bit_cnt(bit_cnt)
  );

  smb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .reg_ptr(reg_ptr),
    .wr_data(wr_data), .strap_ad(strap_ad), .load_done(load_done),
    .pwdn_pin(pwdn_pin), .rd_data(rd_data), .lane_pd(lane_pd),
    .pd_q(pd_q), .wr_seen(wr_seen), .pd_we(pd_we)
  );
endmodule

// File: rtl/smb_lane_ctl_chk.sv
module smb_lane_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       in_ack,
  input logic       in_rd,
  input logic [2:0] bit_cnt,
  input logic [7:0] lane_pd,
  input logic [7:0] wr_data,
  input logic       pd_we,
  input logic       wr_seen
);
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R1 / R3: the line is pulled only in an acknowledge slot or read byte
  p_oe_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (in_ack || in_rd));

  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  p_start_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (bit_cnt == 3'd0 && !sda_oe));

  p_pd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_seen && !pd_we) |=> $stable(lane_pd));

  p_pd_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pd_we |=> (lane_pd == $past(wr_data)));
endmodule

bind smb_lane_ctl smb_lane_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .in_ack(in_ack), .in_rd(in_rd),
  .bit_cnt(bit_cnt), .lane_pd(lane_pd), .wr_data(wr_data), .pd_we(pd_we),
  .wr_seen(wr_seen)
);

// File: tb/test_smb_lane_ctl.sv
module test_smb_lane_ctl;
  localparam logic [6:0] DEV = 7'h58;
  localparam int Q = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, host_sda = 1'b1, pin = 1'b0, done = 1'b0;
  logic [3:0] strap = 4'h0;
  logic sda_oe;
  logic [7:0] lane_pd;
  wire sda_line = host_sda & ~sda_oe;

  int total = 0, bad = 0;
  logic [7:0] m_pd = 8'h00;
  logic m_owned = 1'b0;

  smb_lane_ctl #(.DEV_ADDR(DEV)) i_smb_lane_ctl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_ad(strap), .load_done(done), .pwdn_pin(pin), .lane_pd(lane_pd)
  );

  function automatic logic [7:0] exp_reg(input logic [7:0] p);
    if (p == 8'h00) return (8'(strap) << 3) | (8'(done) << 2);
    if (p == 8'h01) return m_pd;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_lanes();
    return m_owned ? m_pd : (pin ? 8'hFF : 8'h00);
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; w(Q); scl = 1'b1; w(Q); host_sda = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; w(Q); scl = 1'b1; w(Q); host_sda = 1'b1; w(2*Q);
  endtask

  task automatic put_bit(input logic b);
    host_sda = b; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
  endtask

  task automatic get_bit(output logic b);
    host_sda = 1'b1; w(Q); scl = 1'b1; w(Q); @(negedge clk) b = sda_line;
    w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic get_byte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(1'b1);
  endtask

  task automatic reg_write(input logic [7:0] p, input logic [7:0] d,
                           output logic [2:0] acks);
    bus_start();
    put_byte({DEV, 1'b0}, acks[2]);
    put_byte(p, acks[1]);
    put_byte(d, acks[0]);
    bus_stop();
    if (p == 8'h01) begin m_pd = d; m_owned = 1'b1; end
  endtask

  task automatic reg_read(input logic [7:0] p, output logic [7:0] d,
                          output logic [2:0] acks);
    bus_start();
    put_byte({DEV, 1'b0}, acks[2]);
    put_byte(p, acks[1]);
    bus_start();
    put_byte({DEV, 1'b1}, acks[0]);
    get_byte(d);
    @(negedge clk);
    check(sda_oe == 1'b0, "R3 release after NACK", {7'd0, sda_oe}, 8'h00);
    bus_stop();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; scl = 1'b1; host_sda = 1'b1; w(4); rst_n = 1'b1; w(4);
    m_pd = 8'h00; m_owned = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-reqs act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] ak;
    logic [7:0] rd;
    logic a;
    void'($urandom(32'd2024));
    do_reset();

    // reset state
    @(negedge clk);
    check(sda_oe == 1'b0, "R9 oe after reset", {7'd0, sda_oe}, 8'h00);
    check(lane_pd == 8'h00, "R6 pin low owns lanes", lane_pd, 8'h00);
    pin = 1'b1; w(2); @(negedge clk);
    check(lane_pd == 8'hFF, "R6 pin high owns lanes", lane_pd, 8'hFF);

    reg_read(8'h01, rd, ak);
    check(ak == 3'b111, "R3 read acks", {5'd0, ak}, 8'h07);
    check(rd == 8'h00, "R5 reset value", rd, 8'h00);

    // observation register patterns
    for (int i = 0; i < 3; i++) begin
      strap = 4'($urandom()); done = 1'($urandom());
      if (i == 0) begin strap = 4'b1000; done = 1'b1; end
      reg_read(8'h00, rd, ak);
      check(rd == exp_reg(8'h00), "R4 obs layout", rd, exp_reg(8'h00));
    end

    // write and ownership transfer
    reg_write(8'h01, 8'hA5, ak);
    check(ak == 3'b111, "R2 write acks", {5'd0, ak}, 8'h07);
    @(negedge clk);
    check(lane_pd == 8'hA5, "R2 lanes follow write", lane_pd, 8'hA5);
    pin = 1'b0; w(3); @(negedge clk);
    check(lane_pd == 8'hA5, "R6 pin ignored after write", lane_pd, 8'hA5);
    pin = 1'b1; w(3); @(negedge clk);
    check(lane_pd == 8'hA5, "R6 pin ignored after write", lane_pd, 8'hA5);
    reg_read(8'h01, rd, ak);
    check(rd == 8'hA5, "R5 readback", rd, 8'hA5);

    reg_write(8'h01, 8'hFF, ak); @(negedge clk);
    check(lane_pd == 8'hFF, "R5 all lanes off", lane_pd, 8'hFF);
    reg_write(8'h01, 8'h00, ak); @(negedge clk);
    check(lane_pd == 8'h00, "R5 all lanes on", lane_pd, 8'h00);
    reg_write(8'h01, 8'h81, ak); @(negedge clk);
    check(lane_pd == 8'h81, "R5 chan A lane3 and chan B lane0", lane_pd, 8'h81);

    // ignored writes and unmapped reads
    reg_write(8'h00, 8'hFF, ak);
    check(ak == 3'b111, "R7 write to read-only acked", {5'd0, ak}, 8'h07);
    reg_read(8'h00, rd, ak);
    check(rd == exp_reg(8'h00), "R7 read-only unchanged", rd, exp_reg(8'h00));
    reg_write(8'h33, 8'h5A, ak);
    reg_read(8'h33, rd, ak);
    check(rd == 8'h00, "R7 unmapped reads zero", rd, 8'h00);
    @(negedge clk);
    check(lane_pd == 8'h81, "R7 unmapped write no effect", lane_pd, 8'h81);

    // address mismatch
    bus_start();
    put_byte({DEV ^ 7'h01, 1'b0}, ak[2]);
    put_byte(8'h01, ak[1]);
    put_byte(8'h3C, ak[0]);
    bus_stop();
    check(ak == 3'b000, "R1 mismatch never acked", {5'd0, ak}, 8'h00);
    @(negedge clk);
    check(lane_pd == 8'h81, "R1 mismatch no write", lane_pd, 8'h81);
    bus_start();
    put_byte({DEV ^ 7'h40, 1'b1}, a);
    get_byte(rd);
    bus_stop();
    check(a == 1'b0 && rd == 8'hFF, "R1 mismatch read silent", rd, 8'hFF);

    // STOP in the middle of a data byte
    bus_start();
    put_byte({DEV, 1'b0}, a); put_byte(8'h01, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop(); @(negedge clk);
    check(lane_pd == 8'h81, "R8 stop aborts byte", lane_pd, 8'h81);
    // START in the middle of the address byte, then a full write
    bus_start();
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_start();
    put_byte({DEV, 1'b0}, ak[2]); put_byte(8'h01, ak[1]); put_byte(8'h42, ak[0]);
    bus_stop(); m_pd = 8'h42; @(negedge clk);
    check(ak == 3'b111 && lane_pd == 8'h42, "R8 start restarts", lane_pd, 8'h42);

    // constrained random mix
    for (int i = 0; i < 36; i++) begin
      logic [7:0] p, d;
      int sel;
      sel = int'($urandom_range(0, 3));
      p = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h01 : (sel == 2) ? 8'h01 : 8'($urandom_range(2, 255));
      d = 8'($urandom());
      strap = 4'($urandom()); done = 1'($urandom()); pin = 1'($urandom());
      if ($urandom_range(0, 1) == 1) begin
        reg_write(p, d, ak);
        check(ak == 3'b111, "R2 random write acks", {5'd0, ak}, 8'h07);
      end else begin
        reg_read(p, rd, ak);
        check(rd == exp_reg(p), "R3 random read", rd, exp_reg(p));
      end
      @(negedge clk);
      check(lane_pd == exp_lanes(), "R6 random lanes", lane_pd, exp_lanes());
    end

    // second reset hands lanes back to the pin
    pin = 1'b1;
    do_reset(); @(negedge clk);
    check(lane_pd == 8'hFF, "R6 pin owns after reset", lane_pd, 8'hFF);
    reg_read(8'h01, rd, ak);
    check(rd == 8'h00, "R5 reset clears register", rd, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule